// File: doc/BRIEF.md
# NAND Chunk Parity Generator

This block computes a 3-byte Hamming parity code over a 256-byte chunk as the bytes move through a NAND controller's data register. The controller raises a byte strobe for every byte it transfers in either direction. While the engine is accumulating, each strobed byte is folded into a set of line-parity and column-parity accumulators. The position of the byte in the chunk comes from an internal byte index. Software later compares the code against the code stored in the flash spare area and corrects single-bit errors itself.

A 2-bit mode field, held in the controller's mode register, sets what the engine does. Mode 11 clears it. Mode 00 holds the accumulated parity. Mode 01 folds in transferred bytes. Mode 10 turns the shared data-register read path over to the code. To arm the engine, software writes clear, then off, then accumulate. To collect the code, it writes off, then readout, makes three data-register reads, and writes off again. The three reads return code byte 1, then code byte 0, then code byte 2.

Top module: `nand_ecc_gen`

## Requirements
- R1: The mode input is decoded as 2'b11 = clear, 2'b10 = readout, 2'b01 = accumulate and 2'b00 = off.
- R2: A clock edge with mode clear zeroes every parity accumulator, the byte index and the readout pointer. After it, the three code bytes read 8'hFF, 8'hFF, 8'hFF.
- R3: In accumulate mode, each cycle with `xfer_vld` high folds `xfer_byte` into the parity at the current byte index, and then advances the index by one. The index wraps from 255 to 0.
- R4: A strobed byte in off or readout mode leaves the code unchanged.
- R5: Line parity is built per index bit k (k = 0..7). even[k] is the XOR of the byte parities (XOR of all 8 bits) of bytes whose index bit k is 0, and odd[k] is the same over bytes whose index bit k is 1. Code byte 0 is the inverse of {odd3,even3,odd2,even2,odd1,even1,odd0,even0}. Code byte 1 is the same pattern for k = 7..4.
- R6: Column parity is formed over C, the XOR of all accumulated bytes. For data-bit-position bit j (j = 0..2), ce[j] is the XOR of the bits of C whose position has bit j = 0, and co[j] is the same over positions with bit j = 1. Code byte 2 is {~co2,~ce2,~co1,~ce1,~co0,~ce0,1,1}.
- R7: In readout mode, `code_byte` shows the byte at the readout pointer in the same cycle. Each cycle with `code_rd` high advances the pointer. Successive reads return code byte 1, code byte 0, then code byte 2.
- R8: A fourth read in readout mode wraps back to code byte 1.
- R9: Outside readout mode, `code_byte` is 0 and `code_rd` does not move the readout pointer. The pointer keeps its position across mode changes other than clear.
- R10: A byte strobed at a clock edge is reflected in the code read in the very next cycle.
- R11: `rst_n` low at a clock edge has the same effect as mode clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_mode | input | 2 | Engine mode field (clear/readout/accumulate/off) |
| xfer_vld | input | 1 | A byte passes through the data register this cycle |
| xfer_byte | input | 8 | The byte being transferred |
| code_rd | input | 1 | Data-register read strobe |
| code_byte | output | 8 | Code byte returned on a data-register read in readout mode |

## Verification
The accumulators and the readout pointer are the only state, and each moves at the clock edge that samples its strobe. The parity of a byte strobed at one edge is therefore visible from the next cycle. The read path is combinational from the mode input and the pointer, so `code_byte` is valid within the same cycle that `code_rd` is presented. The bench drives inputs just after a falling edge and samples `code_byte` one nanosecond later, which is before the rising edge that consumes the read. A read in the cycle straight after the last accumulated byte checks the one-cycle latency of R10.

// File: rtl/nand_ecc_pkg.sv
// Shared definitions for the NAND chunk parity generator.
// Assumes the mode field encoding fixed by the controller's mode register.
package nand_ecc_pkg;
    // R1: engine mode encoding
    typedef enum logic [1:0] {
        ECC_OFF     = 2'b00,
        ECC_ACCUM   = 2'b01,
        ECC_READOUT = 2'b10,
        ECC_CLEAR   = 2'b11
    } ecc_mode_e;

    // Number of code bytes returned in readout mode.
    localparam int ECC_CODE_BYTES = 3;
endpackage

// File: rtl/ecc_line_parity.sv
// Line-parity accumulator. Tracks the byte index within the chunk and,
// for every index bit, keeps even/odd parity of the byte parities.
// Assumes CHUNK_BYTES is a power of two; the index wraps at the chunk size.
module ecc_line_parity #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [DATA_W-1:0] din,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [IDX_W-1:0]  par_even,
    output logic [IDX_W-1:0]  par_odd
);
    logic             byte_par;
    logic [IDX_W-1:0] idx_q;

    // Parity of the incoming byte.
    assign byte_par = ^din;

    // Byte index: cleared by reset/clear, advanced per accumulated byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx_q <= '0;
        end else if (acc_en) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // One even/odd accumulator pair per index bit.
    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        logic even_q;
        logic odd_q;

        // Fold the byte parity into the half selected by index bit k.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                even_q <= 1'b0;
                odd_q  <= 1'b0;
            end else if (acc_en) begin
                if (idx_q[k]) begin
                    odd_q <= odd_q ^ byte_par;
                end else begin
                    even_q <= even_q ^ byte_par;
                end
            end
        end

        assign par_even[k] = even_q;
        assign par_odd[k]  = odd_q;
    end

    assign byte_idx = idx_q;
endmodule

// File: rtl/ecc_col_parity.sv
// Column-parity accumulator. Keeps the running XOR of all accumulated
// bytes and derives, per bit of the data-bit position, even/odd parities.
// Assumes DATA_W is a power of two.
module ecc_col_parity #(
    parameter int DATA_W = 8,
    localparam int POS_W = $clog2(DATA_W),
    localparam int CP_W  = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [DATA_W-1:0] din,
    output logic [CP_W-1:0]   col_par
);
    logic [DATA_W-1:0] col_q;

    // Select the data-bit positions whose position bit j equals hi.
    function automatic logic [DATA_W-1:0] pos_mask(input int j, input bit hi);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < DATA_W; b++) begin
            m[b] = (((b >> j) & 1) == int'(hi));
        end
        return m;
    endfunction

    // Running XOR of every accumulated byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col_q <= '0;
        end else if (acc_en) begin
            col_q <= col_q ^ din;
        end
    end

    // Even half at 2j, odd half at 2j+1.
    for (genvar j = 0; j < POS_W; j++) begin : g_col
        assign col_par[2*j]   = ^(col_q & pos_mask(j, 1'b0));
        assign col_par[2*j+1] = ^(col_q & pos_mask(j, 1'b1));
    end
endmodule

// File: rtl/ecc_readout.sv
// Readout sequencer. Holds a pointer over the code bytes and returns them
// in the fixed order byte 1, byte 0, byte 2, wrapping after the last.
// Assumes the code word is packed {byte2, byte1, byte0}.
module ecc_readout #(
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 3,
    localparam int PTR_W    = $clog2(NUM_SLOTS),
    localparam int CODE_W   = NUM_SLOTS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] code_word,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] sel_byte
);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);

    logic [PTR_W-1:0] ptr_q;

    // Pointer: cleared by reset/clear, stepped per read, wraps after last.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_q <= '0;
        end else if (rd_en) begin
            ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
        end
    end

    // Slot to code byte mapping: slot0->byte1, slot1->byte0, slot2->byte2.
    always_comb begin
        case (ptr_q)
            PTR_W'(1): sel_byte = code_word[0*DATA_W +: DATA_W];
            PTR_W'(2): sel_byte = code_word[2*DATA_W +: DATA_W];
            default:   sel_byte = code_word[1*DATA_W +: DATA_W];
        endcase
    end

    assign rd_ptr = ptr_q;
endmodule

// File: rtl/nand_ecc_gen.sv
// NAND chunk parity generator top. Decodes the mode field, feeds the
// transferred bytes to the line and column accumulators, packs the
// inverted parities into the code word and serves it through the read path.
// Assumes defaults (8-bit bytes, 256-byte chunk) so the code is 3 bytes.
module nand_ecc_gen #(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ecc_mode,
    input  logic              xfer_vld,
    input  logic [DATA_W-1:0] xfer_byte,
    input  logic              code_rd,
    output logic [DATA_W-1:0] code_byte
);
    import nand_ecc_pkg::*;

    localparam int IDX_W  = $clog2(CHUNK_BYTES);
    localparam int LP_W   = 2 * IDX_W;
    localparam int CP_W   = 2 * $clog2(DATA_W);
    localparam int PAD_W  = DATA_W - CP_W;
    localparam int CODE_W = ECC_CODE_BYTES * DATA_W;
    localparam int PTR_W  = $clog2(ECC_CODE_BYTES);

    ecc_mode_e         mode;
    logic              clr;
    logic              acc_en;
    logic              rd_en;
    logic [IDX_W-1:0]  byte_idx;
    logic [IDX_W-1:0]  par_even;
    logic [IDX_W-1:0]  par_odd;
    logic [LP_W-1:0]   line_par;
    logic [CP_W-1:0]   col_par;
    logic [CODE_W-1:0] code_word;
    logic [PTR_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] sel_byte;

    // Mode decode.
    assign mode   = ecc_mode_e'(ecc_mode);
    assign clr    = (mode == ECC_CLEAR);
    assign acc_en = (mode == ECC_ACCUM) && xfer_vld;
    assign rd_en  = (mode == ECC_READOUT) && code_rd;

    ecc_line_parity #(
        .DATA_W      (DATA_W),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .acc_en   (acc_en),
        .din      (xfer_byte),
        .byte_idx (byte_idx),
        .par_even (par_even),
        .par_odd  (par_odd)
    );

    ecc_col_parity #(
        .DATA_W (DATA_W)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .acc_en  (acc_en),
        .din     (xfer_byte),
        .col_par (col_par)
    );

    // Interleave line parity: even of index bit k at 2k, odd at 2k+1.
    for (genvar k = 0; k < IDX_W; k++) begin : g_pack
        assign line_par[2*k]   = par_even[k];
        assign line_par[2*k+1] = par_odd[k];
    end

    // Code word {byte2, byte1, byte0}: stored parity inverted, pad bits set.
    assign code_word = {~col_par, {PAD_W{1'b1}}, ~line_par};

    ecc_readout #(
        .DATA_W    (DATA_W),
        .NUM_SLOTS (ECC_CODE_BYTES)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rd_en     (rd_en),
        .code_word (code_word),
        .rd_ptr    (rd_ptr),
        .sel_byte  (sel_byte)
    );

    // Read path only carries the code while in readout mode.
    assign code_byte = (mode == ECC_READOUT) ? sel_byte : '0;
endmodule

// File: rtl/nand_ecc_gen_chk.sv
// Property checker for nand_ecc_gen, bound to every instance of it.
// Observes the ports plus the packed code word, byte index and pointer.
module nand_ecc_gen_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter int CODE_W = 24,
    parameter int PTR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ecc_mode,
    input logic              xfer_vld,
    input logic              code_rd,
    input logic [DATA_W-1:0] code_byte,
    input logic [CODE_W-1:0] code_word,
    input logic [IDX_W-1:0]  byte_idx,
    input logic [PTR_W-1:0]  rd_ptr
);
    // R2: clear leaves an all-ones code
    a_r2_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b11) |=> (code_word == {CODE_W{1'b1}}));

    // R2: clear zeroes byte index and readout pointer
    a_r2_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b11) |=> (byte_idx == '0 && rd_ptr == '0));

    // R3: each accumulated byte advances the index by one
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b01 && xfer_vld) |=> ((byte_idx - $past(byte_idx)) == IDX_W'(1)));

    // R4: off mode holds the code
    a_r4_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b00) |=> $stable(code_word));

    // R4: readout mode holds the code
    a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b10) |=> $stable(code_word));

    // R6: third slot carries the two set pad bits
    a_r6_pad_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b10 && rd_ptr == PTR_W'(2)) |-> (code_byte[1:0] == 2'b11));

    // R7: a read before the last slot steps the pointer
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b10 && code_rd && rd_ptr != PTR_W'(2)) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R8: a read at the last slot wraps to the first
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b10 && code_rd && rd_ptr == PTR_W'(2)) |=> (rd_ptr == '0));

    // R9: pointer does not move in off or accumulate mode
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_mode == 2'b00 || ecc_mode == 2'b01) |=> $stable(rd_ptr));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CODE_W (CODE_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_mode  (ecc_mode),
    .xfer_vld  (xfer_vld),
    .code_rd   (code_rd),
    .code_byte (code_byte),
    .code_word (code_word),
    .byte_idx  (byte_idx),
    .rd_ptr    (rd_ptr)
);

// File: tb/nand_ecc_gen_test.sv
`timescale 1ns/1ps
module nand_ecc_gen_test;
    localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ecc_mode = M_OFF;
    logic       xfer_vld = 1'b0;
    logic [7:0] xfer_byte = 8'h00;
    logic       code_rd = 1'b0;
    logic [7:0] code_byte;

    int checks = 0;
    int failures = 0;
    logic [7:0] dbuf [0:511];

    always #2.5 clk = ~clk;

    nand_ecc_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_mode  (ecc_mode),
        .xfer_vld  (xfer_vld),
        .xfer_byte (xfer_byte),
        .code_rd   (code_rd),
        .code_byte (code_byte)
    );

    // Vectors: {kind, seed, byte count}
    localparam logic [31:0] VEC [8] = '{
        {8'd0, 8'h00, 16'd256}, {8'd0, 8'hFF, 16'd256},
        {8'd1, 8'h00, 16'd256}, {8'd2, 8'h05, 16'd256},
        {8'd3, 8'hA5, 16'd256}, {8'd3, 8'h3C, 16'd100},
        {8'd1, 8'h07, 16'd300}, {8'd3, 8'h11, 16'd1}
    };

    function automatic logic [7:0] gen_byte(input int kind, input int seed, input int i);
        case (kind)
            0: return 8'(seed);
            1: return 8'(i + seed);
            2: return (i == seed) ? 8'h10 : 8'h00;
            default: return 8'((i * 37 + seed) ^ (i >> 3));
        endcase
    endfunction

    // Reference code {b2,b1,b0} over dbuf[0..n-1], index taken modulo 256.
    function automatic logic [23:0] model_ecc(input int n);
        logic [7:0] le = '0, lo = '0, col = '0, b0, b1, b2;
        logic [5:0] cp;
        for (int i = 0; i < n; i++) begin
            logic p = ^dbuf[i];
            logic [7:0] idx = 8'(i);
            for (int k = 0; k < 8; k++) begin
                if (idx[k]) lo[k] = lo[k] ^ p; else le[k] = le[k] ^ p;
            end
            col = col ^ dbuf[i];
        end
        cp = {^(col & 8'hF0), ^(col & 8'h0F), ^(col & 8'hCC),
              ^(col & 8'h33), ^(col & 8'hAA), ^(col & 8'h55)};
        b0 = ~{lo[3], le[3], lo[2], le[2], lo[1], le[1], lo[0], le[0]};
        b1 = ~{lo[7], le[7], lo[6], le[6], lo[5], le[5], lo[4], le[4]};
        b2 = {~cp, 2'b11};
        return {b2, b1, b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        ecc_mode = m; xfer_vld = 1'b0; code_rd = 1'b0;
        step();
    endtask

    // Accumulate dbuf[0..n-1], one byte per cycle; leaves mode ACC, vld low.
    task automatic feed(input int n);
        ecc_mode = M_ACC;
        for (int i = 0; i < n; i++) begin
            xfer_vld = 1'b1; xfer_byte = dbuf[i];
            step();
        end
        xfer_vld = 1'b0;
    endtask

    // One read in readout mode: sample in the strobe cycle, then clock it.
    task automatic read_one(input string req, input logic [7:0] exp);
        ecc_mode = M_RD; code_rd = 1'b1; xfer_vld = 1'b0;
        #1;
        check(req, code_byte, exp);
        step();
        code_rd = 1'b0;
    endtask

    task automatic read_code(input string req, input logic [23:0] exp);
        read_one(req, exp[15:8]);
        read_one(req, exp[7:0]);
        read_one(req, exp[23:16]);
        set_mode(M_OFF);
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] exp;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R11 reset state and R9 quiet output outside readout
        #1 check("R9 idle output", code_byte, 8'h00);
        read_code("R11 reset code", 24'hFFFFFF);

        // Table of vectors: R3/R5/R6/R7 main function
        foreach (VEC[v]) begin
            int kind = int'(VEC[v][31:24]);
            int seed = int'(VEC[v][23:16]);
            int n = int'(VEC[v][15:0]);
            for (int i = 0; i < n; i++) dbuf[i] = gen_byte(kind, seed, i);
            set_mode(M_CLR);   // R1: 11 clears
            set_mode(M_OFF);
            feed(n);
            set_mode(M_OFF);
            read_code("R3/R5/R6/R7 vector code", model_ecc(n));
        end

        // R4: bytes in off and readout modes are ignored
        for (int i = 0; i < 256; i++) dbuf[i] = gen_byte(3, 8'h5A, i);
        set_mode(M_CLR); set_mode(M_OFF);
        feed(10);
        ecc_mode = M_OFF;
        for (int i = 0; i < 20; i++) begin xfer_vld = 1'b1; xfer_byte = 8'hC3; step(); end
        ecc_mode = M_RD;
        for (int i = 0; i < 3; i++) begin xfer_vld = 1'b1; xfer_byte = 8'h81; step(); end
        xfer_vld = 1'b0;
        exp = model_ecc(10);
        read_code("R4 ignored bytes", exp);

        // R8: fourth read wraps to byte 1, fifth gives byte 0
        read_one("R7 first", exp[15:8]);
        read_one("R7 second", exp[7:0]);
        read_one("R7 third", exp[23:16]);
        read_one("R8 wrap", exp[15:8]);
        read_one("R8 after wrap", exp[7:0]);
        // pointer now at slot 2; R9: reads in off mode do not move it
        ecc_mode = M_OFF; code_rd = 1'b1;
        #1 check("R9 output off", code_byte, 8'h00);
        step(); step();
        code_rd = 1'b0;
        read_one("R9 pointer held", exp[23:16]);
        set_mode(M_OFF);

        // R2: clear mid-read resets pointer and index
        read_one("R2 pre-clear", exp[15:8]);   // pointer at slot 1
        set_mode(M_CLR);
        set_mode(M_OFF);
        for (int i = 0; i < 256; i++) dbuf[i] = gen_byte(1, 8'h40, i);
        feed(256);
        set_mode(M_OFF);
        read_code("R2 clear restarts", model_ecc(256));

        // R2: clear after a partial chunk restarts the index at 0
        for (int i = 0; i < 256; i++) dbuf[i] = gen_byte(3, 8'h99, i);
        feed(37);
        set_mode(M_CLR);
        feed(5);
        set_mode(M_OFF);
        read_code("R2 index cleared", model_ecc(5));

        // R10: read in the cycle right after the last accumulated byte
        set_mode(M_CLR);
        for (int i = 0; i < 4; i++) dbuf[i] = 8'(8'h21 * (i + 1));
        feed(4);
        exp = model_ecc(4);
        read_code("R10 next-cycle code", exp);

        // R11: reset pulse mid-chunk
        feed(3);
        rst_n = 1'b0; ecc_mode = M_OFF; step();
        rst_n = 1'b1;
        read_code("R11 reset clears", 24'hFFFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule